// File: doc/BRIEF.md
# Snoopy Five-State Cache Line Coherence Controller

This block keeps one cache coherent on a shared snooping bus. The cache is small and direct-mapped. Each line carries one of five coherence states: Invalid, Shared, Exclusive, Owned or Modified. The state of a line changes for only two reasons: an access from the local processor, or a transaction from another cache that this block snoops on the bus. When an access cannot complete locally, the controller raises a bus request. It then carries out the transaction in the single cycle in which the arbiter grants the bus. Memory behind the bus answers with no delay.

A line in the Owned state holds dirty data that other caches may also hold. When another cache reads a Modified line, this cache hands the data over straight away and keeps ownership. It does not write the line to memory first. A write to a shared copy does not fetch the line again. It uses an upgrade transaction that only invalidates the other copies. An external select input names one holder of a clean copy as the cache that supplies the data on a bus read.

Top module: `moesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid. No snoop hits any line, the first processor access to any line misses, and bus_req and cpu_done are low.
- R2: A read miss issues a bus read (bus_cmd 0) for the requested address. The data on bus_rdata fills the line. The line becomes Exclusive when bus_shared is low in the grant cycle, and Shared when it is high.
- R3: A read hit in the Shared, Exclusive, Owned or Modified state raises no bus request and leaves the state unchanged. The cached data is returned on cpu_rdata in the cycle cpu_done is high. cpu_done lasts one cycle and is never high together with bus_req.
- R4: A write hit in Exclusive or Modified raises no bus request. The line becomes Modified and holds the written data.
- R5: A write hit in Shared or Owned issues an upgrade (bus_cmd 2) for the address. On grant the line becomes Modified with the written data.
- R6: A write miss issues a read-for-ownership (bus_cmd 1). On grant the line becomes Modified and holds the written data. A pending request keeps its command and address stable until it is granted, unless a snoop arrives in between.
- R7: A snooped bus read (snp_cmd 0) that hits a Modified line asserts snp_flush with the line data and moves the line to Owned. On an Exclusive line it moves the line to Shared.
- R8: A snooped bus read that hits an Owned line asserts snp_flush with the line data, and the line stays Owned.
- R9: A snooped read-for-ownership (1) or upgrade (2) that hits moves the line to Invalid. A Modified or Owned line flushes its data on a read-for-ownership, and no line flushes on an upgrade. A snooped write-back (3) changes nothing.
- R10: A Shared or Exclusive line supplies its data on a snooped read or read-for-ownership only while snp_opt_sel is high.
- R11: A miss whose victim line is Modified or Owned first issues a write-back (bus_cmd 3) carrying the victim's address and data, and only then issues the fill request. A clean victim is dropped without a bus transaction.
- R12: snp_hit is high exactly while a valid snoop matches a line that is not Invalid. This is this cache's contribution to the shared-line signal.
- R13: If a snoop invalidates the line while an upgrade is waiting for grant, the request turns into a read-for-ownership. A processor access is held off in any cycle that carries a snoop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held until cpu_done |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Access address; low bits select the line |
| cpu_wdata | input | DATA_W | Write data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data (for writes, the written value) |
| bus_req | output | 1 | Bus request |
| bus_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 upgrade, 3 write-back |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_gnt | input | 1 | Grant; the transaction takes place in this cycle |
| bus_shared | input | 1 | Shared-line value in the grant cycle |
| bus_rdata | input | DATA_W | Fill data in the grant cycle |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same coding as bus_cmd |
| snp_addr | input | ADDR_W | Snooped address |
| snp_opt_sel | input | 1 | This cache is the chosen supplier for clean copies |
| snp_hit | output | 1 | Snoop matches a valid line |
| snp_flush | output | 1 | This cache drives data for the snoop |
| snp_data | output | DATA_W | Flushed line data |

## Verification
The bench goes after the states that are only told apart by later behaviour. An Exclusive fill that is wrongly marked Shared would issue a needless upgrade on the next write. A Modified line that fell to Shared instead of Owned on a snooped read would stop supplying data, and its dirty data would be lost at eviction. A victim that is dirty but not written back shows up as a fill with no write-back before it. An upgrade left pending after its line was invalidated by a snoop would make the cache Modified without any data. The bench also drives a clean supplier with the select input both high and low, and sends write-back snoops that must leave the line as it was.

// File: rtl/moesi_snoop_ctrl.sv
`timescale 1ns/1ps
module moesi_snoop_ctrl #(
  parameter int LINES  = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic              bus_shared,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              snp_opt_sel,
  output logic              snp_hit,
  output logic              snp_flush,
  output logic [DATA_W-1:0] snp_data
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  localparam logic [2:0] ST_I = 3'd0, ST_S = 3'd1, ST_E = 3'd2, ST_O = 3'd3, ST_M = 3'd4;
  localparam logic [1:0] CMD_RD = 2'd0, CMD_RDX = 2'd1, CMD_UPG = 2'd2, CMD_WB = 2'd3;

  typedef enum logic [1:0] {P_IDLE, P_WB, P_REQ, P_DONE} phase_t;

  phase_t            phase_q;
  logic [2:0]        st_q  [LINES];
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES];
  logic [DATA_W-1:0] rdata_q;

  logic [IDX_W-1:0] c_idx, s_idx;
  logic [TAG_W-1:0] c_tag, s_tag;
  logic [2:0]       c_st, s_st;
  logic             c_hit, c_dirty, wb_needed;
  logic [1:0]       req_cmd;

  assign c_idx = cpu_addr[IDX_W-1:0];
  assign c_tag = cpu_addr[ADDR_W-1:IDX_W];
  assign c_st  = st_q[c_idx];
  assign c_hit = (c_st != ST_I) && (tag_q[c_idx] == c_tag);
  assign c_dirty   = (c_st == ST_M) || (c_st == ST_O);
  assign wb_needed = !c_hit && c_dirty;
  assign req_cmd   = (c_hit && cpu_we) ? CMD_UPG : (cpu_we ? CMD_RDX : CMD_RD);

  assign s_idx = snp_addr[IDX_W-1:0];
  assign s_tag = snp_addr[ADDR_W-1:IDX_W];
  assign s_st  = st_q[s_idx];
  assign snp_hit   = snp_valid && (s_st != ST_I) && (tag_q[s_idx] == s_tag);
  assign snp_flush = snp_hit && (snp_cmd == CMD_RD || snp_cmd == CMD_RDX) &&
                     ((s_st == ST_M) || (s_st == ST_O) ||
                      (((s_st == ST_E) || (s_st == ST_S)) && snp_opt_sel));
  assign snp_data  = dat_q[s_idx];

  assign bus_req   = ((phase_q == P_WB) && wb_needed) || (phase_q == P_REQ);
  assign bus_cmd   = (phase_q == P_WB) ? CMD_WB : req_cmd;
  assign bus_addr  = (phase_q == P_WB) ? {tag_q[c_idx], c_idx} : cpu_addr;
  assign bus_wdata = dat_q[c_idx];
  assign cpu_done  = (phase_q == P_DONE);
  assign cpu_rdata = rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= P_IDLE;
      rdata_q <= '0;
      for (int i = 0; i < LINES; i++) st_q[i] <= ST_I;
    end else begin
      if (snp_hit) begin
        case (snp_cmd)
          CMD_RD: begin
            if (s_st == ST_M) st_q[s_idx] <= ST_O;
            if (s_st == ST_E) st_q[s_idx] <= ST_S;
          end
          CMD_RDX, CMD_UPG: st_q[s_idx] <= ST_I;
          default: ;
        endcase
      end
      case (phase_q)
        P_IDLE: if (cpu_req && !snp_valid) begin
          if (c_hit && !cpu_we) begin
            rdata_q <= dat_q[c_idx];
            phase_q <= P_DONE;
          end else if (c_hit && (c_st == ST_E || c_st == ST_M)) begin
            st_q[c_idx]  <= ST_M;
            dat_q[c_idx] <= cpu_wdata;
            rdata_q      <= cpu_wdata;
            phase_q      <= P_DONE;
          end else begin
            phase_q <= wb_needed ? P_WB : P_REQ;
          end
        end
        P_WB: begin
          if (!wb_needed) phase_q <= P_REQ;
          else if (bus_gnt) begin
            st_q[c_idx] <= ST_I;
            phase_q     <= P_REQ;
          end
        end
        P_REQ: if (bus_gnt) begin
          tag_q[c_idx] <= c_tag;
          if (req_cmd == CMD_RD) begin
            st_q[c_idx]  <= bus_shared ? ST_S : ST_E;
            dat_q[c_idx] <= bus_rdata;
            rdata_q      <= bus_rdata;
          end else begin
            st_q[c_idx]  <= ST_M;
            dat_q[c_idx] <= cpu_wdata;
            rdata_q      <= cpu_wdata;
          end
          phase_q <= P_DONE;
        end
        default: phase_q <= P_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/moesi_snoop_ctrl_chk.sv
`timescale 1ns/1ps
module moesi_snoop_ctrl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_we,
  input logic              cpu_done,
  input logic              bus_req,
  input logic [1:0]        bus_cmd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_gnt,
  input logic              snp_valid,
  input logic [1:0]        snp_cmd,
  input logic              snp_hit,
  input logic              snp_flush
);
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !bus_req && !cpu_done); // R1
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done); // R3
  AST_DONE_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> !bus_req); // R3
  AST_UPG_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_cmd == 2'd2) |-> cpu_we); // R5
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt && !snp_valid) |=> bus_req && $stable(bus_cmd) && $stable(bus_addr)); // R6
  AST_NO_FLUSH_UPG: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_cmd == 2'd2) |-> !snp_flush); // R9
  AST_FLUSH_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |-> snp_hit); // R10
  AST_HIT_NEEDS_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
    snp_hit |-> snp_valid); // R12
endmodule

bind moesi_snoop_ctrl moesi_snoop_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_done(cpu_done),
  .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_gnt(bus_gnt),
  .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_hit(snp_hit), .snp_flush(snp_flush)
);

// File: tb/moesi_snoop_ctrl_tb_top.sv
`timescale 1ns/1ps
module moesi_snoop_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 8, ADDR_W = 8, DATA_W = 16, IDX_W = 3;
  localparam logic [2:0] I = 0, S = 1, E = 2, O = 3, M = 4;
  localparam logic [1:0] RD = 0, RDX = 1, UPG = 2, WB = 3;

  logic clk = 0, rst_n = 0;
  logic cpu_req = 0, cpu_we = 0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0;
  logic cpu_done;
  logic [DATA_W-1:0] cpu_rdata;
  logic bus_req;
  logic [1:0] bus_cmd;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic bus_gnt = 0, bus_shared = 0;
  logic [DATA_W-1:0] bus_rdata = '0;
  logic snp_valid = 0, snp_opt_sel = 0;
  logic [1:0] snp_cmd = '0;
  logic [ADDR_W-1:0] snp_addr = '0;
  logic snp_hit, snp_flush;
  logic [DATA_W-1:0] snp_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  moesi_snoop_ctrl #(.LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_gnt(bus_gnt), .bus_shared(bus_shared), .bus_rdata(bus_rdata),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr), .snp_opt_sel(snp_opt_sel),
    .snp_hit(snp_hit), .snp_flush(snp_flush), .snp_data(snp_data));

  int checks = 0, fails = 0;
  int sh_mode = 2;
  logic [2:0]              m_st  [LINES];
  logic [ADDR_W-IDX_W-1:0] m_tag [LINES];
  logic [DATA_W-1:0]       m_dat [LINES];

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit m_hit(logic [ADDR_W-1:0] a);
    return m_st[a[IDX_W-1:0]] != I && m_tag[a[IDX_W-1:0]] == a[ADDR_W-1:IDX_W];
  endfunction

  function automatic bit is_dirty(logic [2:0] st);
    return st == M || st == O;
  endfunction

  task automatic cpu_op(bit we, logic [ADDR_W-1:0] a, logic [DATA_W-1:0] wd, bit inj, string req);
    int idx = int'(a[IDX_W-1:0]);
    bit hit0 = m_hit(a);
    bit need_bus = !(hit0 && (!we || m_st[idx] == E || m_st[idx] == M));
    bit got = 0, got_main = 0, injected = 0, sh;
    int wait_c = $urandom % 3;
    int cyc = 0;
    logic [DATA_W-1:0] got_rd = '0, rd, exp_rd;
    logic [1:0] ecmd;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    while (!got) begin
      @(negedge clk);
      cyc++;
      bus_gnt = 0;
      snp_valid = 0;
      if (cyc > 60) begin chk(0, req, cyc, 0); break; end
      if (cpu_done) begin
        got = 1; got_rd = cpu_rdata;
      end else if (bus_req) begin
        if (!need_bus) chk(0, req, 1, 0);
        if (inj && !injected) begin
          injected = 1;
          snp_valid = 1; snp_cmd = RDX; snp_addr = a; snp_opt_sel = 0;
          if (m_hit(a)) m_st[idx] = I;
        end else if (wait_c > 0) begin
          wait_c--;
        end else begin
          if (!m_hit(a) && is_dirty(m_st[idx])) begin
            chk(bus_cmd == WB, req, bus_cmd, WB);
            chk(bus_addr == {m_tag[idx], a[IDX_W-1:0]}, req, bus_addr, {m_tag[idx], a[IDX_W-1:0]});
            chk(bus_wdata == m_dat[idx], req, bus_wdata, m_dat[idx]);
            m_st[idx] = I;
          end else begin
            ecmd = (m_hit(a) && we) ? UPG : (we ? RDX : RD);
            chk(bus_cmd == ecmd, req, bus_cmd, ecmd);
            chk(bus_addr == a, req, bus_addr, a);
            got_main = 1;
          end
          sh = (sh_mode == 2) ? bit'($urandom % 2) : bit'(sh_mode);
          rd = DATA_W'($urandom);
          bus_gnt = 1; bus_shared = sh; bus_rdata = rd;
          if (got_main) begin
            m_tag[idx] = a[ADDR_W-1:IDX_W];
            if (ecmd == RD) begin m_st[idx] = sh ? S : E; m_dat[idx] = rd; end
            else begin m_st[idx] = M; m_dat[idx] = wd; end
          end
          wait_c = $urandom % 3;
        end
      end
    end
    cpu_req = 0; bus_gnt = 0; snp_valid = 0;
    if (!need_bus && we) begin m_st[idx] = M; m_dat[idx] = wd; end
    exp_rd = we ? wd : m_dat[idx];
    chk(got_rd == exp_rd, req, got_rd, exp_rd);
    chk(got_main == need_bus, req, got_main, need_bus);
  endtask

  task automatic snoop(logic [1:0] c, logic [ADDR_W-1:0] a, bit sel, string req);
    int idx = int'(a[IDX_W-1:0]);
    bit hit = m_hit(a);
    bit fl;
    @(negedge clk);
    snp_valid = 1; snp_cmd = c; snp_addr = a; snp_opt_sel = sel;
    #1;
    fl = hit && (c == RD || c == RDX) &&
         (is_dirty(m_st[idx]) || ((m_st[idx] == E || m_st[idx] == S) && sel));
    chk(snp_hit == hit, req, snp_hit, hit);
    chk(snp_flush == fl, req, snp_flush, fl);
    if (fl) chk(snp_data == m_dat[idx], req, snp_data, m_dat[idx]);
    if (hit) begin
      if (c == RD && m_st[idx] == M) m_st[idx] = O;
      else if (c == RD && m_st[idx] == E) m_st[idx] = S;
      else if (c == RDX || c == UPG) m_st[idx] = I;
    end
    @(negedge clk);
    snp_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < LINES; i++) begin m_st[i] = I; m_tag[i] = '0; m_dat[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!bus_req, "R1", bus_req, 0);
    chk(!cpu_done, "R1", cpu_done, 0);
    for (int i = 0; i < LINES; i++) snoop(RD, ADDR_W'(i), 1, "R1");

    sh_mode = 0;
    cpu_op(0, 8'h05, 16'h0, 0, "R2");
    cpu_op(1, 8'h05, 16'hA1A1, 0, "R4");
    cpu_op(1, 8'h05, 16'hA2A2, 0, "R4");
    snoop(RD, 8'h05, 0, "R7");
    snoop(RD, 8'h05, 0, "R8");
    cpu_op(0, 8'h05, 16'h0, 0, "R3");
    cpu_op(1, 8'h05, 16'hB0B0, 0, "R5");
    cpu_op(0, 8'h06, 16'h0, 0, "R2");
    snoop(RD, 8'h06, 0, "R7");
    cpu_op(1, 8'h06, 16'h1234, 0, "R5");

    sh_mode = 1;
    cpu_op(0, 8'h0A, 16'h0, 0, "R2");
    cpu_op(0, 8'h0A, 16'h0, 0, "R3");
    snoop(RD, 8'h0A, 1, "R10");
    snoop(RD, 8'h0A, 0, "R10");
    snoop(UPG, 8'h0A, 1, "R9");
    snoop(RD, 8'h0A, 0, "R12");

    cpu_op(0, 8'h0D, 16'h0, 0, "R11");
    cpu_op(0, 8'h15, 16'h0, 0, "R11");

    cpu_op(0, 8'h02, 16'h0, 0, "R13");
    cpu_op(1, 8'h02, 16'hC3C3, 1, "R13");
    cpu_op(0, 8'h02, 16'h0, 0, "R13");

    cpu_op(1, 8'h33, 16'h5A5A, 0, "R6");
    snoop(RDX, 8'h33, 0, "R9");
    cpu_op(0, 8'h07, 16'h0, 0, "R2");
    snoop(WB, 8'h07, 0, "R9");
    snoop(RD, 8'h07, 1, "R9");
    cpu_op(1, 8'h07, 16'h7777, 0, "R5");
    snoop(RDX, 8'h07, 0, "R9");

    sh_mode = 2;
    for (int n = 0; n < 400; n++) begin
      logic [ADDR_W-1:0] a = ADDR_W'($urandom % 32);
      int k = $urandom % 10;
      if (k < 3) cpu_op(0, a, 16'h0, 0, "R3");
      else if (k < 6) cpu_op(1, a, DATA_W'($urandom), 0, "R6");
      else snoop(2'($urandom % 4), a, bit'($urandom % 2), "R9");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule